// File: doc/BRIEF.md
# Random Number Generator Peripheral with Seed-Error Recovery

This block is a memory-mapped random number source with three 32-bit registers: control at offset 0x0, status at offset 0x4 and data at offset 0x8. An external entropy word input is sampled at a programmable pace into a small output FIFO. Software drains the FIFO through the data register. The `ent_take` output pulses in each cycle whose closing clock edge samples `ent_word`, so an entropy source can step to its next word.

The block detects seed (noise source) faults and clock faults and raises sticky flags for both. It offers two ways to recover from a seed fault. The first is an automatic recovery that restarts the generator by itself. The second is a software-driven conditional reset handshake. The configuration fields (clock-error-detect disable, auto-recovery enable and fill divider) are loaded only by a control write that also sets the conditional reset bit. A plain control write leaves them unchanged.

Top module: `rng_periph`

## Requirements
- R1: After reset, the control, status and data registers all read 0 and `irq` is low.
- R2: While control bit 2 (enable) is 1, the FIFO is not full, no seed error is current and no conditional reset is active, one entropy word is sampled every FILL_N << div clocks, where div is control bits 19:16. `ent_take` is high in each cycle that ends with a sample.
- R3: The FIFO holds FIFO_DEPTH words and returns them through the data register in sampling order. Status bit 0 is 1 exactly when at least one word is held. A data read while the FIFO is empty returns 0 and removes nothing.
- R4: Control bits 29:4 (bit 5 clock-error-detect disable, bit 7 auto-recovery enable, bits 19:16 divider) are loaded only by a control write with bit 30 = 1. Any other control write leaves them unchanged. Bits 2 (enable) and 3 (interrupt enable) are taken from every control write.
- R5: A control write with bit 30 = 1 holds the generator in conditional reset. The next control write with bit 30 = 0 starts an internal reset cycle lasting RST_CYC clocks. Bit 30 reads 1 from the first write to the end of that cycle. The FIFO is emptied and sampling stops throughout. At the end of the cycle, status bit 2 clears and sampling resumes.
- R6: A seed fault sets status bit 2 (seed error current) and bit 6 (seed error flag), and stops sampling. While bit 2 is set, data reads return 0.
- R7: With auto-recovery off (control bit 7 = 0), status bit 2 stays set until a conditional reset cycle completes.
- R8: With auto-recovery on, status bit 2 clears by itself RST_CYC clocks after it was set, the FIFO is emptied, and status bit 6 stays set.
- R9: With control bit 5 = 0, status bit 1 follows `clock_fault` one clock later and status bit 5 latches it. With control bit 5 = 1, `clock_fault` has no effect.
- R10: A status write clears bit 5 or bit 6 where the written bit is 0 and leaves it unchanged where the written bit is 1. All other status bits ignore writes.
- R11: `irq` equals control bit 3 AND (status bit 5 OR status bit 6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (a data read pops one word) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address and strobe |
| ent_word | input | 32 | Entropy word from the noise source |
| ent_take | output | 1 | High in each cycle whose closing edge samples `ent_word` |
| seed_fault | input | 1 | Seed error indication from the noise source |
| clock_fault | input | 1 | Clock error indication |
| irq | output | 1 | Interrupt request |

## Verification
The fill path is tested with the divider at 0 and at 1. The spacing between `ent_take` pulses distinguishes a correct divider shift from an off-by-one or a missing shift. The words read back are compared in order against the values the bench's own LFSR offered on each sampling pulse, which catches ordering and pointer faults.

Seed faults are injected twice, once with auto-recovery off and once with it on. The number of cycles status bit 2 stays high, and the exact status word that follows, separate the auto path from the handshake path. The same checks also catch a wrong reset cycle length and a missed FIFO flush. Control writes with and without bit 30, and status writes of 0 and 1, show that the configuration and the sticky flags change only on the intended patterns.

// File: rtl/rng_pkg.sv
package rng_pkg;

   localparam int REG_W     = 32;

   // register byte offsets
   localparam int CTRL_OFS  = 0;
   localparam int STAT_OFS  = 4;
   localparam int DATA_OFS  = 8;

   // control bit positions
   localparam int CB_EN     = 2;
   localparam int CB_IE     = 3;
   localparam int CB_CED    = 5;
   localparam int CB_AREC   = 7;
   localparam int CB_DIV_LO = 16;
   localparam int DIV_W     = 4;
   localparam int CB_CRST   = 30;

   // status bit positions
   localparam int SB_RDY    = 0;
   localparam int SB_CEC    = 1;
   localparam int SB_SEC    = 2;
   localparam int SB_CEI    = 5;
   localparam int SB_SEI    = 6;

   typedef struct packed {
      logic [DIV_W-1:0] div;
      logic             arec;
      logic             ced;
   } rng_cfg_t;

endpackage

// File: rtl/rng_fifo.sv
module rng_fifo #(
   parameter int DEPTH = 4,
   parameter int W     = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  logic         flush,
   input  logic [W-1:0] din,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = AW + 1;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("rng_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [CW-1:0] cnt;

   assign empty = (cnt == '0);
   assign full  = (cnt == CW'(DEPTH));
   assign head  = mem[rp];

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else if (flush) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push) wp <= wp + AW'(1);
         if (pop)  rp <= rp + AW'(1);
         cnt <= cnt + {{AW{1'b0}}, push} - {{AW{1'b0}}, pop};
      end
   end

   // R3
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !push);
   // R3
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> !pop);

endmodule

// File: rtl/rng_ctrl.sv
module rng_ctrl
   import rng_pkg::*;
#(
   parameter int RST_CYC = 16
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     wr_ctrl,
   input  logic     w_en,
   input  logic     w_ie,
   input  logic     w_crst,
   input  rng_cfg_t w_cfg,
   output logic     en,
   output logic     ie,
   output rng_cfg_t cfg,
   output logic     sub_reset,
   output logic     reset_done
);
   localparam int CW = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;

   generate
      if (RST_CYC < 2) begin : g_bad_rst
         $error("rng_ctrl: RST_CYC must be at least 2");
      end
   endgenerate

   logic          hold, busy;
   logic [CW-1:0] cnt;

   assign reset_done = busy && (cnt == CW'(RST_CYC - 1));
   assign sub_reset  = hold | busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en   <= 1'b0;
         ie   <= 1'b0;
         cfg  <= '0;
         hold <= 1'b0;
         busy <= 1'b0;
         cnt  <= '0;
      end else begin
         if (busy) begin
            if (reset_done) begin
               busy <= 1'b0;
               cnt  <= '0;
            end else begin
               cnt <= cnt + CW'(1);
            end
         end
         if (wr_ctrl) begin
            en <= w_en;
            ie <= w_ie;
            if (w_crst) begin
               hold <= 1'b1;
               cfg  <= w_cfg;
            end else if (hold) begin
               hold <= 1'b0;
               busy <= 1'b1;
               cnt  <= '0;
            end
         end
      end
   end

   // R4
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_ctrl && w_crst) |=> $stable(cfg));

endmodule

// File: rtl/rng_status.sv
module rng_status #(
   parameter int RST_CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_stat,
   input  logic keep_cei,
   input  logic keep_sei,
   input  logic seed_fault,
   input  logic clock_fault,
   input  logic ced,
   input  logic arec,
   input  logic reset_done,
   output logic secs,
   output logic seis,
   output logic cecs,
   output logic ceis,
   output logic auto_done
);
   localparam int CW = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;

   logic [CW-1:0] ar_cnt;
   logic          clk_err;

   assign clk_err   = clock_fault & ~ced;
   assign auto_done = secs && arec && (ar_cnt == CW'(RST_CYC - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         secs   <= 1'b0;
         seis   <= 1'b0;
         cecs   <= 1'b0;
         ceis   <= 1'b0;
         ar_cnt <= '0;
      end else begin
         cecs <= clk_err;
         if (clk_err)                   ceis <= 1'b1;
         else if (wr_stat && !keep_cei) ceis <= 1'b0;

         if (seed_fault)                seis <= 1'b1;
         else if (wr_stat && !keep_sei) seis <= 1'b0;

         if (seed_fault)                     secs <= 1'b1;
         else if (reset_done || auto_done)   secs <= 1'b0;

         if (!(secs && arec) || auto_done) ar_cnt <= '0;
         else                              ar_cnt <= ar_cnt + CW'(1);
      end
   end

   // R6
   seed_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seed_fault |=> (secs && seis));
   // R8
   auto_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_done && !seed_fault && !wr_stat) |=> (!secs && $stable(seis)));

endmodule

// File: rtl/rng_filler.sv
module rng_filler #(
   parameter int FILL_N = 8,
   parameter int DIV_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             halt,
   input  logic             full,
   input  logic [DIV_W-1:0] div,
   output logic             take
);
   localparam int MAX_SH = (1 << DIV_W) - 1;
   localparam int CW     = $clog2(FILL_N) + MAX_SH + 1;

   generate
      if (FILL_N < 2) begin : g_bad_fill
         $error("rng_filler: FILL_N must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt, period;
   logic          active;

   assign period = CW'(FILL_N) << div;
   assign active = en & ~halt & ~full;
   assign take   = active && (cnt == period - CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt <= '0;
      else if (!active || take) cnt <= '0;
      else                      cnt <= cnt + CW'(1);
   end

endmodule

// File: rtl/rng_periph.sv
module rng_periph
   import rng_pkg::*;
#(
   parameter int ADDR_W     = 4,
   parameter int FIFO_DEPTH = 4,
   parameter int FILL_N     = 8,
   parameter int RST_CYC    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [REG_W-1:0]  bus_wdata,
   output logic [REG_W-1:0]  bus_rdata,
   input  logic [REG_W-1:0]  ent_word,
   output logic              ent_take,
   input  logic              seed_fault,
   input  logic              clock_fault,
   output logic              irq
);
   generate
      if (ADDR_W < 4) begin : g_bad_addr
         $error("rng_periph: ADDR_W must cover offset 0x8");
      end
   endgenerate

   logic sel_ctrl, sel_stat, sel_data;
   logic wr_ctrl, wr_stat, pop;
   logic en, ie, sub_reset, reset_done;
   logic secs, seis, cecs, ceis, auto_done;
   logic empty, full;
   logic [REG_W-1:0] head, ctrl_rd, stat_rd, data_rd;
   rng_cfg_t cfg, w_cfg;
   logic unused_wbits;

   assign sel_ctrl = (bus_addr == ADDR_W'(CTRL_OFS));
   assign sel_stat = (bus_addr == ADDR_W'(STAT_OFS));
   assign sel_data = (bus_addr == ADDR_W'(DATA_OFS));
   assign wr_ctrl  = bus_wr & sel_ctrl;
   assign wr_stat  = bus_wr & sel_stat;
   assign pop      = bus_rd & sel_data & ~empty;
   assign unused_wbits = ^bus_wdata;

   assign w_cfg.div  = bus_wdata[CB_DIV_LO +: DIV_W];
   assign w_cfg.arec = bus_wdata[CB_AREC];
   assign w_cfg.ced  = bus_wdata[CB_CED];

   rng_ctrl #(.RST_CYC(RST_CYC)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_ctrl    (wr_ctrl),
      .w_en       (bus_wdata[CB_EN]),
      .w_ie       (bus_wdata[CB_IE]),
      .w_crst     (bus_wdata[CB_CRST]),
      .w_cfg      (w_cfg),
      .en         (en),
      .ie         (ie),
      .cfg        (cfg),
      .sub_reset  (sub_reset),
      .reset_done (reset_done)
   );

   rng_status #(.RST_CYC(RST_CYC)) u_status (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_stat     (wr_stat),
      .keep_cei    (bus_wdata[SB_CEI]),
      .keep_sei    (bus_wdata[SB_SEI]),
      .seed_fault  (seed_fault),
      .clock_fault (clock_fault),
      .ced         (cfg.ced),
      .arec        (cfg.arec),
      .reset_done  (reset_done),
      .secs        (secs),
      .seis        (seis),
      .cecs        (cecs),
      .ceis        (ceis),
      .auto_done   (auto_done)
   );

   rng_filler #(.FILL_N(FILL_N), .DIV_W(DIV_W)) u_filler (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en),
      .halt  (secs | sub_reset),
      .full  (full),
      .div   (cfg.div),
      .take  (ent_take)
   );

   rng_fifo #(.DEPTH(FIFO_DEPTH), .W(REG_W)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (ent_take),
      .pop   (pop),
      .flush (sub_reset | auto_done),
      .din   (ent_word),
      .head  (head),
      .empty (empty),
      .full  (full)
   );

   always_comb begin
      ctrl_rd = '0;
      ctrl_rd[CB_EN]               = en;
      ctrl_rd[CB_IE]               = ie;
      ctrl_rd[CB_CED]              = cfg.ced;
      ctrl_rd[CB_AREC]             = cfg.arec;
      ctrl_rd[CB_DIV_LO +: DIV_W]  = cfg.div;
      ctrl_rd[CB_CRST]             = sub_reset;
      stat_rd = '0;
      stat_rd[SB_RDY] = ~empty;
      stat_rd[SB_CEC] = cecs;
      stat_rd[SB_SEC] = secs;
      stat_rd[SB_CEI] = ceis;
      stat_rd[SB_SEI] = seis;
      data_rd = (empty || secs) ? '0 : head;
      bus_rdata = '0;
      if (bus_rd) begin
         if (sel_ctrl)      bus_rdata = ctrl_rd;
         else if (sel_stat) bus_rdata = stat_rd;
         else if (sel_data) bus_rdata = data_rd;
      end
   end

   assign irq = ie & (seis | ceis);

   // R6
   halt_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (secs || sub_reset) |-> !ent_take);

endmodule

// File: tb/rng_periph_tb.sv
module rng_periph_tb;
   localparam int FILL_N  = 4;
   localparam int RST_CYC = 16;
   localparam int DEPTH   = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic [31:0] lfsr = 32'hACE1_2345;
   logic        ent_take, irq;
   logic        seed_fault = 1'b0, clock_fault = 1'b0;

   int checks = 0, errors = 0, cyc = 0, tk_n = 0;
   int tk [512];
   logic [31:0] mq [$];

   always #10 clk = ~clk;

   rng_periph #(.ADDR_W(4), .FIFO_DEPTH(DEPTH), .FILL_N(FILL_N),
                .RST_CYC(RST_CYC)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ent_word(lfsr), .ent_take(ent_take), .seed_fault(seed_fault),
      .clock_fault(clock_fault), .irq(irq));

   // entropy stand-in: new word each negedge, recorded when it will be sampled
   always @(negedge clk) begin
      cyc = cyc + 1;
      lfsr = {lfsr[30:0], 1'b0} ^ (lfsr[31] ? 32'h04C1_1DB7 : 32'h0);
      if (ent_take) begin
         mq.push_back(lfsr);
         if (tk_n < 512) tk[tk_n] = cyc;
         tk_n = tk_n + 1;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] v);
      bus_addr = a; bus_rd = 1'b1;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_takes(input int base, input int n);
      int g = 0;
      while (tk_n < base + n && g < 5000) begin
         @(negedge clk);
         g++;
      end
   endtask

   task automatic check_gaps(input string req, input int base, input int exp);
      for (int i = 0; i < DEPTH - 1; i++)
         check(req, tk[base + i + 1] - tk[base + i], exp);
   endtask

   task automatic read_word(input string req);
      logic [31:0] v, e;
      rd(4'h8, v);
      e = (mq.size() > 0) ? mq.pop_front() : 32'hDEAD_BEEF;
      check(req, v, e);
   endtask

   task automatic count_high(input logic [3:0] a, input int bitn, output int n,
                             output logic [31:0] last);
      logic [31:0] v;
      n = 0;
      for (int k = 0; k < 200; k++) begin
         rd(a, v);
         if (!v[bitn]) break;
         n++;
      end
      last = v;
   endtask

   initial begin
      repeat (400000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int n, base;
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // reset state
      rd(4'h0, v); check("R1 ctrl", v, 32'h0);
      rd(4'h4, v); check("R1 status", v, 32'h0);
      rd(4'h8, v); check("R1 data", v, 32'h0);
      check("R11 irq after reset", {31'b0, irq}, 32'h0);

      // fill at divider 0, then drain in order
      base = tk_n;
      wr(4'h0, 32'h4);
      wait_takes(base, DEPTH);
      check_gaps("R2 period div0", base, FILL_N);
      idle(2);
      wr(4'h0, 32'h0);
      rd(4'h4, v); check("R3 ready when full", v, 32'h1);
      for (int i = 0; i < DEPTH; i++) read_word("R3 order");
      rd(4'h4, v); check("R3 ready low when empty", v, 32'h0);
      rd(4'h8, v); check("R3 empty read", v, 32'h0);
      rd(4'h4, v); check("R3 empty read no pop", v, 32'h0);

      // config ignored without bit 30
      wr(4'h0, 32'h0003_00A4);
      rd(4'h0, v); check("R4 cfg ignored", v, 32'h4);

      // config loaded with bit 30, then reset cycle length
      wr(4'h0, 32'h4001_0004);
      mq.delete();
      rd(4'h0, v); check("R4 cfg loaded", v, 32'h4001_0004);
      wr(4'h0, 32'h0001_0004);
      count_high(4'h0, 30, n, v);
      check("R5 reset cycle length", n, RST_CYC);
      check("R5 ctrl after reset", v, 32'h0001_0004);
      base = tk_n;
      wait_takes(base, DEPTH);
      check_gaps("R2 period div1", base, FILL_N * 2);
      idle(2);
      for (int i = 0; i < DEPTH; i++) read_word("R3 order div1");

      // clock error with detection on
      clock_fault = 1'b1;
      idle(1);
      rd(4'h4, v); check("R9 clock error current", v & 32'h66, 32'h22);
      clock_fault = 1'b0;
      idle(1);
      rd(4'h4, v); check("R9 clock flag sticky", v & 32'h66, 32'h20);
      check("R11 irq masked", {31'b0, irq}, 32'h0);
      wr(4'h0, 32'h0001_000C);
      check("R11 irq raised", {31'b0, irq}, 32'h1);
      wr(4'h4, 32'h40);
      rd(4'h4, v); check("R10 clear clock flag", v & 32'h66, 32'h0);
      check("R11 irq dropped", {31'b0, irq}, 32'h0);

      // clock error with detection off
      wr(4'h0, 32'h4001_002C);
      wr(4'h0, 32'h0001_000C);
      idle(RST_CYC + 2);
      clock_fault = 1'b1;
      idle(2);
      clock_fault = 1'b0;
      idle(1);
      rd(4'h4, v); check("R9 clock fault ignored", v & 32'h66, 32'h0);

      // seed error, manual recovery
      idle(60);
      rd(4'h4, v); check("R3 full before seed fault", v, 32'h1);
      seed_fault = 1'b1;
      idle(1);
      seed_fault = 1'b0;
      mq.delete();
      check("R11 irq on seed flag", {31'b0, irq}, 32'h1);
      rd(4'h4, v); check("R6 seed flags", v, 32'h45);
      rd(4'h8, v); check("R6 late read zero", v, 32'h0);
      base = tk_n;
      idle(40);
      check("R6 sampling stopped", tk_n - base, 0);
      rd(4'h4, v); check("R7 seed current held", v, 32'h45);
      wr(4'h4, 32'h40);
      rd(4'h4, v); check("R10 write one keeps", v, 32'h45);
      wr(4'h4, 32'h0);
      rd(4'h4, v); check("R10 write zero clears", v, 32'h05);
      wr(4'h0, 32'h4001_000C);
      wr(4'h0, 32'h0001_000C);
      idle(RST_CYC);
      rd(4'h4, v); check("R5 seed current cleared", v, 32'h0);
      base = tk_n;
      wait_takes(base, 1);
      idle(2);
      read_word("R5 sampling resumed");

      // seed error, auto recovery
      wr(4'h0, 32'h4000_0084);
      mq.delete();
      wr(4'h0, 32'h0000_0084);
      idle(RST_CYC + 40);
      rd(4'h4, v); check("R3 full before auto case", v, 32'h1);
      seed_fault = 1'b1;
      idle(1);
      seed_fault = 1'b0;
      mq.delete();
      count_high(4'h4, 2, n, v);
      check("R8 auto recovery length", n, RST_CYC);
      check("R8 flag kept and fifo flushed", v, 32'h40);
      wr(4'h4, 32'h0);
      rd(4'h4, v); check("R10 clear seed flag", v & 32'h40, 32'h0);
      base = tk_n;
      wait_takes(base, 1);
      idle(2);
      read_word("R8 sampling resumed");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule